// File: doc/BRIEF.md
# Byte-Lane Data Memory for a RISC-V Load/Store Path

This block is the data memory behind a small RISC-V core's load/store unit. The core sends one request at a time on a valid/ready channel. Each request carries a byte address, the funct3 code of the load or store instruction, a write flag and 32 bits of store data. The storage is an array of 32-bit words. Byte addressing exists only at the interface: the word index is the byte address shifted right by two, and it wraps modulo the depth. Stores change only the 8-bit lanes selected by a four-bit mask. The mask is decoded from funct3 and the low two address bits.

A load reads one whole word in the cycle its request is accepted. One cycle later it presents that word on a valid/ready response channel. The word is shifted right so the addressed byte or halfword sits at bit 0, then sign- or zero-extended as funct3 asks. A misaligned access is flagged and is never split across words; a misaligned store writes nothing. Back-pressure rules: a response, once valid, holds its data unchanged until `rsp_ready` is high. A request is accepted only when `req_ready` is high. `req_ready` is high whenever no response is waiting or the waiting one is being taken in the same cycle. Only loads produce responses.

Top module: `dmem_bytelane`

## Requirements
- R1: The word touched by an access is the one at index (req_addr >> 2) modulo DEPTH (DEPTH a power of two, default 1024), so byte address 0x1000 reaches the same word as address 0x0000.
- R2: A byte store (funct3 000) writes only lane req_addr[1:0], where lane i is bits [8i+7:8i] of the word; other lanes keep their value.
- R3: A halfword store (funct3 001) writes lanes req_addr[1:0] and req_addr[1:0]+1 only.
- R4: A word store (funct3 010) writes all four lanes. Store codes 011 and 1xx write no lane.
- R5: Lane i of a store takes bits [8i+7:8i] of req_wdata shifted left by 8 × req_addr[1:0], so store data given in the low bits lands at the addressed byte.
- R6: Memory changes only on a cycle with req_valid, req_ready and req_write all high. Loads and non-accepted requests leave it unchanged.
- R7: A load (req_write low) accepted at a clock edge makes rsp_valid high after that edge. rsp_rdata is then the word as it stood before that edge, shifted right by 8 × req_addr[1:0].
- R8: On the shifted word, funct3 000 sign-extends bits [7:0], 001 sign-extends [15:0], 100 zero-extends [7:0] and 101 zero-extends [15:0]. 010 and the remaining codes return the shifted word unchanged.
- R9: req_misaligned is high when funct3[1:0] is 01 with req_addr[0] = 1, or funct3[1:0] is 10 with req_addr[1:0] ≠ 00. A misaligned store writes nothing; a misaligned load still answers per R7 and R8.
- R10: While rsp_valid is high and rsp_ready low, rsp_valid stays high, rsp_rdata stays unchanged and req_ready is low.
- R11: After reset, rsp_valid is low and req_ready is high.
- R12: A store accepted in the same cycle a load response is taken does not alter that response, which still shows the word read at the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_funct3 | input | 3 | Load/store funct3 code |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| req_misaligned | output | 1 | Current request is misaligned (meaningful with req_valid) |
| rsp_valid | output | 1 | Load response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Realigned, extended load data |

## Verification
Draining a load response and accepting a store to the same word can happen at the same clock edge. The bench provokes this by holding rsp_ready low behind a load response while a store to that word waits at the request port. It then releases rsp_ready and samples the response data just before the edge where both happen. The response must still show the pre-store word, and a later load must show the stored word.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_NONE = 2'b11
  } acc_size_e;

  typedef enum logic [2:0] {
    LD_BYTE_S = 3'b000,
    LD_HALF_S = 3'b001,
    LD_WORD   = 3'b010,
    LD_BYTE_U = 3'b100,
    LD_HALF_U = 3'b101
  } load_kind_e;
endpackage

// File: rtl/dmem_lane_decode.sv
module dmem_lane_decode
  import dmem_pkg::*;
(
  input  logic [2:0]        funct3,
  input  logic [1:0]        offset,
  input  logic [WORD_W-1:0] wdata,
  output logic [LANES-1:0]  lane_mask,
  output logic [WORD_W-1:0] lane_data,
  output logic              misaligned
);
  acc_size_e          size;
  logic [LANES-1:0]   base_mask;

  always_comb begin
    size       = acc_size_e'(funct3[1:0]);
    misaligned = ((size == SZ_HALF) && offset[0]) ||
                 ((size == SZ_WORD) && (offset != 2'b00));
    base_mask  = '0;
    if (!funct3[2]) begin
      case (size)
        SZ_BYTE: base_mask = 4'b0001;
        SZ_HALF: base_mask = 4'b0011;
        SZ_WORD: base_mask = 4'b1111;
        default: base_mask = 4'b0000;
      endcase
    end
    lane_mask = misaligned ? '0 : (base_mask << offset);
    lane_data = wdata << {offset, 3'b000};
  end
endmodule

// File: rtl/dmem_word_array.sv
module dmem_word_array
  import dmem_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [WORD_W-1:0] lane_data,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int ln = 0; ln < LANES; ln++) begin
        if (lane_mask[ln])
          words[idx][ln*LANE_W +: LANE_W] <= lane_data[ln*LANE_W +: LANE_W];
      end
    end
    if (rd_en)
      rd_word <= words[idx];
  end
endmodule

// File: rtl/dmem_load_align.sv
module dmem_load_align
  import dmem_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [2:0]        funct3,
  input  logic [1:0]        offset,
  output logic [WORD_W-1:0] data
);
  logic [WORD_W-1:0] shifted;

  always_comb begin
    shifted = word >> {offset, 3'b000};
    case (funct3)
      LD_BYTE_S: data = {{(WORD_W-8){shifted[7]}}, shifted[7:0]};
      LD_HALF_S: data = {{(WORD_W-16){shifted[15]}}, shifted[15:0]};
      LD_BYTE_U: data = {{(WORD_W-8){1'b0}}, shifted[7:0]};
      LD_HALF_U: data = {{(WORD_W-16){1'b0}}, shifted[15:0]};
      default:   data = shifted;
    endcase
  end
endmodule

// File: rtl/dmem_bytelane.sv
module dmem_bytelane
  import dmem_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2:0]        req_funct3,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_misaligned,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              take, wr_take, rd_take;
  logic [LANES-1:0]  mask;
  logic [WORD_W-1:0] lane_data, rd_word;
  logic [2:0]        q_funct3;
  logic [1:0]        q_offset;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^req_addr[ADDR_W-1:IDX_W+2];

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign wr_take   = take && req_write;
  assign rd_take   = take && !req_write;

  dmem_lane_decode u_dec (
    .funct3    (req_funct3),
    .offset    (req_addr[1:0]),
    .wdata     (req_wdata),
    .lane_mask (mask),
    .lane_data (lane_data),
    .misaligned(req_misaligned)
  );

  dmem_word_array #(.DEPTH(DEPTH)) u_mem (
    .clk      (clk),
    .wr_en    (wr_take),
    .rd_en    (rd_take),
    .idx      (req_addr[IDX_W+1:2]),
    .lane_mask(mask),
    .lane_data(lane_data),
    .rd_word  (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      q_funct3  <= '0;
      q_offset  <= '0;
    end else if (rd_take) begin
      rsp_valid <= 1'b1;
      q_funct3  <= req_funct3;
      q_offset  <= req_addr[1:0];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  dmem_load_align u_align (
    .word  (rd_word),
    .funct3(q_funct3),
    .offset(q_offset),
    .data  (rsp_rdata)
  );
endmodule

// File: rtl/dmem_bytelane_chk.sv
module dmem_bytelane_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [2:0]        req_funct3,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_misaligned,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata
);
  logic unused_chk;
  assign unused_chk = ^req_addr[ADDR_W-1:2];

  a_r7_load_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  a_r8_lbu_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_funct3 == 3'b100) |=> (rsp_rdata[31:8] == 24'h0));

  a_r8_lhu_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_funct3 == 3'b101) |=> (rsp_rdata[31:16] == 16'h0));

  a_r9_word_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_funct3[1:0] == 2'b10 && req_addr[1:0] != 2'b00) |-> req_misaligned);

  a_r9_half_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_funct3[1:0] == 2'b01 && req_addr[0]) |-> req_misaligned);

  a_r10_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r10_stall_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind dmem_bytelane dmem_bytelane_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dmem_bytelane_test.sv
`timescale 1ns/1ps
module dmem_bytelane_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_funct3 = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_misaligned;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dmem_bytelane uut (.*);

  // {write, funct3, addr[15:0], wdata, expected rdata, expected misaligned}
  localparam int NV = 25;
  localparam logic [84:0] VEC [NV] = '{
    {1'b1, 3'd2, 16'h0000, 32'h11223344, 32'h0,        1'b0}, // R4 word store
    {1'b0, 3'd2, 16'h0000, 32'h0,        32'h11223344, 1'b0}, // R7 word load
    {1'b1, 3'd0, 16'h0001, 32'h000000AA, 32'h0,        1'b0}, // R2 R5 byte store lane 1
    {1'b0, 3'd2, 16'h0000, 32'h0,        32'h1122AA44, 1'b0}, // R2
    {1'b1, 3'd1, 16'h0002, 32'h0000BEEF, 32'h0,        1'b0}, // R3 R5 half store upper
    {1'b0, 3'd2, 16'h0000, 32'h0,        32'hBEEFAA44, 1'b0}, // R3
    {1'b0, 3'd0, 16'h0001, 32'h0,        32'hFFFFFFAA, 1'b0}, // R8 LB
    {1'b0, 3'd4, 16'h0001, 32'h0,        32'h000000AA, 1'b0}, // R8 LBU
    {1'b0, 3'd1, 16'h0002, 32'h0,        32'hFFFFBEEF, 1'b0}, // R8 LH
    {1'b0, 3'd5, 16'h0002, 32'h0,        32'h0000BEEF, 1'b0}, // R8 LHU
    {1'b0, 3'd0, 16'h0000, 32'h0,        32'h00000044, 1'b0}, // R8 positive byte
    {1'b0, 3'd0, 16'h0003, 32'h0,        32'hFFFFFFBE, 1'b0}, // R7 offset 3
    {1'b1, 3'd1, 16'h0001, 32'h00001234, 32'h0,        1'b1}, // R9 misaligned half store
    {1'b0, 3'd2, 16'h0000, 32'h0,        32'hBEEFAA44, 1'b0}, // R9 nothing written
    {1'b1, 3'd2, 16'h0004, 32'hCAFEF00D, 32'h0,        1'b0}, // R4
    {1'b1, 3'd2, 16'h0006, 32'h55667788, 32'h0,        1'b1}, // R9 misaligned word store
    {1'b0, 3'd2, 16'h0004, 32'h0,        32'hCAFEF00D, 1'b0}, // R9 nothing written
    {1'b1, 3'd3, 16'h0004, 32'h00000000, 32'h0,        1'b0}, // R4 code 011 writes nothing
    {1'b0, 3'd2, 16'h0004, 32'h0,        32'hCAFEF00D, 1'b0}, // R4
    {1'b1, 3'd2, 16'h1000, 32'hA5A5A5A5, 32'h0,        1'b0}, // R1 wraps to word 0
    {1'b0, 3'd2, 16'h0000, 32'h0,        32'hA5A5A5A5, 1'b0}, // R1
    {1'b0, 3'd1, 16'h0003, 32'h0,        32'h000000A5, 1'b1}, // R9 misaligned load answers
    {1'b0, 3'd0, 16'h0002, 32'h0,        32'hFFFFFFA5, 1'b0}, // R8
    {1'b1, 3'd0, 16'h0007, 32'h00000077, 32'h0,        1'b0}, // R2 R5 lane 3
    {1'b0, 3'd2, 16'h0004, 32'h0,        32'h77FEF00D, 1'b0}  // R5
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [2:0] f3, input logic [31:0] a, input logic [31:0] d);
    req_valid  = 1'b1;
    req_write  = wr;
    req_funct3 = f3;
    req_addr   = a;
    req_wdata  = d;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check(req_ready == 1'b1, "R11 req_ready", {31'h0, req_ready}, 32'h1);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      issue(VEC[v][84], VEC[v][83:81], {16'h0, VEC[v][80:65]}, VEC[v][64:33]);
      #1;
      check(req_misaligned == VEC[v][0], $sformatf("R9 misaligned vector %0d", v),
            {31'h0, req_misaligned}, {31'h0, VEC[v][0]});
      @(negedge clk);
      req_valid = 1'b0;
      if (!VEC[v][84]) begin
        check(rsp_valid == 1'b1, $sformatf("R7 latency vector %0d", v),
              {31'h0, rsp_valid}, 32'h1);
        check(rsp_rdata == VEC[v][32:1], $sformatf("R1 R5 R7 R8 data vector %0d", v),
              rsp_rdata, VEC[v][32:1]);
      end
    end

    // R6: a store that is not valid must not write word 0 (holds A5A5A5A5)
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b1; req_funct3 = 3'd2; req_addr = 32'h0; req_wdata = 32'h0;
    @(negedge clk);
    issue(1'b0, 3'd2, 32'h0, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_rdata == 32'hA5A5A5A5, "R6 idle store ignored", rsp_rdata, 32'hA5A5A5A5);

    // R10: stall a load response, a store waits at the port
    rsp_ready = 1'b0;
    issue(1'b0, 3'd2, 32'h0, 32'h0);
    @(negedge clk);
    issue(1'b1, 3'd2, 32'h0, 32'hFFFFFFFF);
    check(rsp_valid == 1'b1, "R10 valid held", {31'h0, rsp_valid}, 32'h1);
    check(req_ready == 1'b0, "R10 ready low", {31'h0, req_ready}, 32'h0);
    repeat (2) @(negedge clk);
    check(rsp_valid == 1'b1, "R10 still valid", {31'h0, rsp_valid}, 32'h1);
    check(rsp_rdata == 32'hA5A5A5A5, "R10 data stable", rsp_rdata, 32'hA5A5A5A5);

    // R12: release; response drains at the same edge the store is taken
    rsp_ready = 1'b1;
    #1;
    check(req_ready == 1'b1, "R12 ready with drain", {31'h0, req_ready}, 32'h1);
    check(rsp_rdata == 32'hA5A5A5A5, "R12 response before edge", rsp_rdata, 32'hA5A5A5A5);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b0, "R12 response drained", {31'h0, rsp_valid}, 32'h0);
    issue(1'b0, 3'd2, 32'h0, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_rdata == 32'hFFFFFFFF, "R12 store landed", rsp_rdata, 32'hFFFFFFFF);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7 no response without load", {31'h0, rsp_valid}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule